// File: doc/BRIEF.md
# Shared Interrupt Line Router

The router sits between the interrupt request pins of four expansion slots and a sixteen-line interrupt controller. Each slot has four request pins. Each pin has a small routing entry that either leaves the pin unconnected or ties it to one of four steering links. A link carries a target line number, which can be any of 0 to 15 or a disabled value, and a flag that selects level or edge behaviour. Two on-board sources have their own enable, line number and trigger flag. One direct source names its line on a side input. When the `NO_STEER` parameter is set, the links come out of reset edge-triggered instead of level-triggered.

Level-triggered requests share a line through a per-line owner mask. A line goes active when any owner claims it. It drops, with a one-cycle clear strobe, only when the last owner lets go. Edge-triggered requests bypass the mask. An assertion gives a one-cycle pulse, and a release forces the line low with a clear strobe whether or not it has owners.

Requests arrive as one-cycle set and clear strobes. The three output vectors are registered, so each one reflects the strobes sampled at the previous clock edge.

Top module: `irq_router`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `irq_level`, `irq_pulse` and `irq_clear` are all zero. Reset also sets every link to disabled (line field 63), every routing entry to 0 and every on-board source to disabled.
- R2: Configuration writes use `cfg_addr[7:6]` to pick a space: 00 selects routing, 01 selects links, 10 selects on-board sources and 11 is ignored. In the routing space, `cfg_addr[5:0]` = slot*4+pin and `cfg_wdata[2:0]` is the entry. A routing entry of 0 makes the pin unconnected, and its strobes have no effect on any output.
- R3: A nonzero entry e selects link (e-1) mod 4. A link is written at `cfg_addr[5:0]` = link number, with `cfg_wdata[5:0]` as the line and `cfg_wdata[7]` as the trigger (1 = level). A line value above 15 disables the link, and requests through it are ignored.
- R4: A level set drives `irq_level` of its line high one cycle later. Repeating the set keeps the line high and produces no pulse.
- R5: An edge set gives a single-cycle `irq_pulse` on its line. It leaves `irq_level` and the owner mask untouched.
- R6: A level clear from a source that does not own the line changes no output.
- R7: A level clear removes the source from the owner mask. `irq_level` falls, together with a single-cycle `irq_clear`, only when no owner remains.
- R8: An edge clear drops `irq_level` of its line and pulses `irq_clear`, even if level owners remain. Those owners stay in the mask.
- R9: On-board source n is written at `cfg_addr` = {2'b10, n}, with `cfg_wdata[7]` as the enable, `[6]` as the trigger and `[5:0]` as the line. A disabled source is ignored. Each on-board source owns a line separately from the slots.
- R10: The direct source uses `dir_line` and `dir_level` as its target and trigger, and it owns a line separately from all other sources.
- R11: Within one cycle, all sets are applied before any clear, in ascending source index (pins at slot*4+pin, then on-board sources, then direct). A set and a clear from the same level source therefore leave the line low and strobe `irq_clear`.
- R12: Reset empties every owner mask. After reset and reprogramming, a level clear from a former owner produces no clear strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration space and index |
| cfg_wdata | input | 8 | Configuration data |
| pin_set | input | 16 | Set strobes, bit slot*4+pin |
| pin_clr | input | 16 | Clear strobes, bit slot*4+pin |
| ext_set | input | 2 | On-board source set strobes |
| ext_clr | input | 2 | On-board source clear strobes |
| dir_set | input | 1 | Direct source set strobe |
| dir_clr | input | 1 | Direct source clear strobe |
| dir_line | input | 4 | Direct source target line |
| dir_level | input | 1 | Direct source trigger, 1 = level |
| irq_level | output | 16 | Active level per line |
| irq_pulse | output | 16 | Single-cycle edge pulse per line |
| irq_clear | output | 16 | Single-cycle clear strobe per line |

## Verification
The hardest case to reach is a line whose owner mask and output level disagree. This happens when an edge release drops a line that level owners still hold. In that state only a later level release reveals the leftover owners, through a second clear strobe. The directed stimulus gets there by steering an edge link and the direct source onto one line, then releasing them in turn. It also covers same-cycle set and clear on one source and on different owners. A long pseudo-random run with occasional reconfiguration then compares every cycle against a bench model built from the requirements.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int SLOTS      = 4;
    localparam int PINS       = 4;
    localparam int LINKS      = 4;
    localparam int EXTRAS     = 2;
    localparam int LINES      = 16;
    localparam int LINE_W     = $clog2(LINES);
    localparam int LINK_W     = $clog2(LINKS);
    localparam int IRQ_W      = 6;
    localparam int ENTRY_W    = 3;
    localparam int SLOT_SRC   = SLOTS * PINS;
    localparam int NUM_SRC    = SLOT_SRC + EXTRAS + 1;
    localparam int HOLD_W     = SLOTS + 1 + EXTRAS;
    localparam int DIRECT_BIT = SLOTS;
    localparam int EXTRA_BIT0 = SLOTS + 1;
    localparam logic [IRQ_W-1:0] IRQ_OFF = '1;

    typedef logic [HOLD_W-1:0]  hold_t;
    typedef logic [ENTRY_W-1:0] entry_t;

    typedef enum logic [1:0] {
        SP_ROUTE = 2'b00,
        SP_LINK  = 2'b01,
        SP_BOARD = 2'b10,
        SP_NONE  = 2'b11
    } cfg_space_e;

    typedef struct packed {
        logic [IRQ_W-1:0] irq;
        logic             level;
    } link_t;

    typedef struct packed {
        logic             en;
        logic             level;
        logic [IRQ_W-1:0] irq;
    } board_t;

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] line;
        logic              level;
        hold_t             owner;
    } req_t;

    function automatic logic irq_live(input logic [IRQ_W-1:0] n);
        return n < IRQ_W'(LINES);
    endfunction

    function automatic hold_t owner_bit(input int idx);
        return hold_t'(1) << idx;
    endfunction
endpackage

// File: rtl/irq_router_cfg.sv
module irq_router_cfg
    import irq_router_pkg::*;
#(
    parameter bit NO_STEER = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_we,
    input  logic [7:0]                 cfg_addr,
    input  logic [7:0]                 cfg_wdata,
    output entry_t [SLOT_SRC-1:0]      route_o,
    output link_t  [LINKS-1:0]         link_o,
    output board_t [EXTRAS-1:0]        board_o
);
    cfg_space_e space;
    logic [5:0] sel;

    assign space = cfg_space_e'(cfg_addr[7:6]);
    assign sel   = cfg_addr[5:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOT_SRC; i++) route_o[i] <= '0;
            for (int l = 0; l < LINKS; l++)
                link_o[l] <= '{irq: IRQ_OFF, level: ~NO_STEER};
            for (int n = 0; n < EXTRAS; n++)
                board_o[n] <= '{en: 1'b0, level: 1'b1, irq: IRQ_OFF};
        end else if (cfg_we) begin
            for (int i = 0; i < SLOT_SRC; i++)
                if (space == SP_ROUTE && sel == 6'(i))
                    route_o[i] <= cfg_wdata[ENTRY_W-1:0];
            for (int l = 0; l < LINKS; l++)
                if (space == SP_LINK && sel == 6'(l))
                    link_o[l] <= '{irq: cfg_wdata[IRQ_W-1:0], level: cfg_wdata[7]};
            for (int n = 0; n < EXTRAS; n++)
                if (space == SP_BOARD && sel == 6'(n))
                    board_o[n] <= '{en: cfg_wdata[7], level: cfg_wdata[6],
                                    irq: cfg_wdata[IRQ_W-1:0]};
        end
    end
endmodule

// File: rtl/irq_router_resolve.sv
module irq_router_resolve
    import irq_router_pkg::*;
(
    input  entry_t [SLOT_SRC-1:0] route_i,
    input  link_t  [LINKS-1:0]    link_i,
    input  board_t [EXTRAS-1:0]   board_i,
    input  logic   [LINE_W-1:0]   dir_line,
    input  logic                  dir_level,
    output req_t   [NUM_SRC-1:0]  req_o
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        for (genvar p = 0; p < PINS; p++) begin : g_pin
            localparam int IDX = s * PINS + p;
            entry_t            ent;
            logic [LINK_W-1:0] lsel;
            link_t             lk;
            assign ent  = route_i[IDX];
            assign lsel = ent[LINK_W-1:0] - LINK_W'(1);
            assign lk   = link_i[lsel];
            assign req_o[IDX] = '{valid: (ent != '0) && irq_live(lk.irq),
                                  line:  lk.irq[LINE_W-1:0],
                                  level: lk.level,
                                  owner: owner_bit(s)};
        end
    end

    for (genvar n = 0; n < EXTRAS; n++) begin : g_board
        assign req_o[SLOT_SRC+n] = '{valid: board_i[n].en && irq_live(board_i[n].irq),
                                     line:  board_i[n].irq[LINE_W-1:0],
                                     level: board_i[n].level,
                                     owner: owner_bit(EXTRA_BIT0 + n)};
    end

    assign req_o[NUM_SRC-1] = '{valid: 1'b1, line: dir_line, level: dir_level,
                                owner: owner_bit(DIRECT_BIT)};
endmodule

// File: rtl/irq_router_hold.sv
module irq_router_hold
    import irq_router_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  req_t  [NUM_SRC-1:0]      req_i,
    input  logic  [NUM_SRC-1:0]      set_i,
    input  logic  [NUM_SRC-1:0]      clr_i,
    output logic  [LINES-1:0]        level_o,
    output logic  [LINES-1:0]        pulse_o,
    output logic  [LINES-1:0]        clear_o
);
    hold_t [LINES-1:0] hold_q, hold_n;
    logic  [LINES-1:0] act_q, act_n, pulse_n, clear_n, pulse_q, clear_q;

    // Sets first, then clears, each pass in ascending source index.
    always_comb begin
        hold_n  = hold_q;
        act_n   = act_q;
        pulse_n = '0;
        clear_n = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (set_i[i] && req_i[i].valid) begin
                if (req_i[i].level) begin
                    hold_n[req_i[i].line] = hold_n[req_i[i].line] | req_i[i].owner;
                    act_n[req_i[i].line]  = 1'b1;
                end else begin
                    pulse_n[req_i[i].line] = 1'b1;
                end
            end
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (clr_i[i] && req_i[i].valid) begin
                if (req_i[i].level) begin
                    if ((hold_n[req_i[i].line] & req_i[i].owner) != '0) begin
                        hold_n[req_i[i].line] = hold_n[req_i[i].line] & ~req_i[i].owner;
                        if (hold_n[req_i[i].line] == '0) begin
                            act_n[req_i[i].line]   = 1'b0;
                            clear_n[req_i[i].line] = 1'b1;
                        end
                    end
                end else begin
                    act_n[req_i[i].line]   = 1'b0;
                    clear_n[req_i[i].line] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            act_q   <= '0;
            pulse_q <= '0;
            clear_q <= '0;
        end else begin
            hold_q  <= hold_n;
            act_q   <= act_n;
            pulse_q <= pulse_n;
            clear_q <= clear_n;
        end
    end

    assign level_o = act_q;
    assign pulse_o = pulse_q;
    assign clear_o = clear_q;
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter bit NO_STEER = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [7:0]          cfg_addr,
    input  logic [7:0]          cfg_wdata,
    input  logic [SLOT_SRC-1:0] pin_set,
    input  logic [SLOT_SRC-1:0] pin_clr,
    input  logic [EXTRAS-1:0]   ext_set,
    input  logic [EXTRAS-1:0]   ext_clr,
    input  logic                dir_set,
    input  logic                dir_clr,
    input  logic [LINE_W-1:0]   dir_line,
    input  logic                dir_level,
    output logic [LINES-1:0]    irq_level,
    output logic [LINES-1:0]    irq_pulse,
    output logic [LINES-1:0]    irq_clear
);
    entry_t [SLOT_SRC-1:0] route;
    link_t  [LINKS-1:0]    links;
    board_t [EXTRAS-1:0]   boards;
    req_t   [NUM_SRC-1:0]  reqs;
    logic   [NUM_SRC-1:0]  set_all, clr_all;

    assign set_all = {dir_set, ext_set, pin_set};
    assign clr_all = {dir_clr, ext_clr, pin_clr};

    irq_router_cfg #(.NO_STEER(NO_STEER)) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .route_o(route), .link_o(links), .board_o(boards)
    );

    irq_router_resolve u_resolve (
        .route_i(route), .link_i(links), .board_i(boards),
        .dir_line(dir_line), .dir_level(dir_level), .req_o(reqs)
    );

    irq_router_hold u_hold (
        .clk(clk), .rst(rst), .req_i(reqs), .set_i(set_all), .clr_i(clr_all),
        .level_o(irq_level), .pulse_o(irq_pulse), .clear_o(irq_clear)
    );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [SLOT_SRC-1:0] pin_set,
    input logic [SLOT_SRC-1:0] pin_clr,
    input logic [EXTRAS-1:0]   ext_set,
    input logic [EXTRAS-1:0]   ext_clr,
    input logic                dir_set,
    input logic                dir_clr,
    input logic [LINES-1:0]    irq_level,
    input logic [LINES-1:0]    irq_pulse,
    input logic [LINES-1:0]    irq_clear
);
    logic any_set, any_clr;
    assign any_set = (|pin_set) | (|ext_set) | dir_set;
    assign any_clr = (|pin_clr) | (|ext_clr) | dir_clr;

    // R7 / R8: a line that is strobed clear is low in the same cycle
    p_clear_low_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_clear & irq_level) == '0);

    // R4: a line can only rise after some set strobe
    p_rise_needs_set_r4: assert property (@(posedge clk) disable iff (rst)
        ((irq_level & ~$past(irq_level)) != '0) |-> $past(any_set));

    // R5: an edge pulse needs a set strobe in the previous cycle
    p_pulse_needs_set_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse != '0) |-> $past(any_set));

    // R8: a clear strobe needs a clear request in the previous cycle
    p_clear_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_clear != '0) |-> $past(any_clr));

    // R6: with no strobes, nothing moves
    p_idle_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(any_set) && !$past(any_clr)) |->
        (irq_pulse == '0 && irq_clear == '0 && irq_level == $past(irq_level)));
endmodule

bind irq_router irq_router_chk u_chk (
    .clk(clk), .rst(rst), .pin_set(pin_set), .pin_clr(pin_clr),
    .ext_set(ext_set), .ext_clr(ext_clr), .dir_set(dir_set), .dir_clr(dir_clr),
    .irq_level(irq_level), .irq_pulse(irq_pulse), .irq_clear(irq_clear)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;
    import irq_router_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                rst;
    logic                cfg_we;
    logic [7:0]          cfg_addr, cfg_wdata;
    logic [SLOT_SRC-1:0] pin_set, pin_clr;
    logic [EXTRAS-1:0]   ext_set, ext_clr;
    logic                dir_set, dir_clr, dir_level;
    logic [LINE_W-1:0]   dir_line;
    logic [LINES-1:0]    irq_level, irq_pulse, irq_clear;

    irq_router u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pin_set(pin_set), .pin_clr(pin_clr), .ext_set(ext_set), .ext_clr(ext_clr),
        .dir_set(dir_set), .dir_clr(dir_clr), .dir_line(dir_line), .dir_level(dir_level),
        .irq_level(irq_level), .irq_pulse(irq_pulse), .irq_clear(irq_clear)
    );

    int vectors = 0;
    int errors  = 0;

    // bench model of the requirements
    int        m_route [SLOT_SRC];
    int        m_lirq  [LINKS];
    bit        m_llvl  [LINKS];
    int        m_xirq  [EXTRAS];
    bit        m_xlvl  [EXTRAS];
    bit        m_xen   [EXTRAS];
    int        m_hold  [LINES];
    bit [15:0] m_act, m_pulse, m_clr;

    task automatic model_reset();
        for (int i = 0; i < SLOT_SRC; i++) m_route[i] = 0;
        for (int l = 0; l < LINKS; l++) begin m_lirq[l] = 63; m_llvl[l] = 1'b1; end
        for (int n = 0; n < EXTRAS; n++) begin m_xirq[n] = 63; m_xlvl[n] = 1'b1; m_xen[n] = 1'b0; end
        for (int k = 0; k < LINES; k++) m_hold[k] = 0;
        m_act = '0; m_pulse = '0; m_clr = '0;
    endtask

    task automatic m_resolve(input int i, output bit ok, output int line, output bit lvl, output int own);
        if (i < SLOT_SRC) begin
            int e;
            int l;
            e    = m_route[i];
            l    = (e + 3) % 4;
            ok   = (e != 0) && (m_lirq[l] < 16);
            line = m_lirq[l] % 16;
            lvl  = m_llvl[l];
            own  = 1 << (i / PINS);
        end else if (i < SLOT_SRC + EXTRAS) begin
            int n;
            n    = i - SLOT_SRC;
            ok   = m_xen[n] && (m_xirq[n] < 16);
            line = m_xirq[n] % 16;
            lvl  = m_xlvl[n];
            own  = 1 << (SLOTS + 1 + n);
        end else begin
            ok   = 1'b1;
            line = int'(dir_line);
            lvl  = dir_level;
            own  = 1 << SLOTS;
        end
    endtask

    function automatic bit m_is_set(input int i);
        if (i < SLOT_SRC) return pin_set[i];
        if (i < SLOT_SRC + EXTRAS) return ext_set[i - SLOT_SRC];
        return dir_set;
    endfunction

    function automatic bit m_is_clr(input int i);
        if (i < SLOT_SRC) return pin_clr[i];
        if (i < SLOT_SRC + EXTRAS) return ext_clr[i - SLOT_SRC];
        return dir_clr;
    endfunction

    task automatic model_step();
        bit [15:0] np, nc;
        bit ok, lvl;
        int line, own;
        np = '0; nc = '0;
        if (rst) begin
            model_reset();
            return;
        end
        for (int i = 0; i < NUM_SRC; i++) if (m_is_set(i)) begin
            m_resolve(i, ok, line, lvl, own);
            if (ok) begin
                if (lvl) begin m_hold[line] = m_hold[line] | own; m_act[line] = 1'b1; end
                else np[line] = 1'b1;
            end
        end
        for (int i = 0; i < NUM_SRC; i++) if (m_is_clr(i)) begin
            m_resolve(i, ok, line, lvl, own);
            if (ok) begin
                if (lvl) begin
                    if ((m_hold[line] & own) != 0) begin
                        m_hold[line] = m_hold[line] & ~own;
                        if (m_hold[line] == 0) begin m_act[line] = 1'b0; nc[line] = 1'b1; end
                    end
                end else begin
                    m_act[line] = 1'b0; nc[line] = 1'b1;
                end
            end
        end
        m_pulse = np; m_clr = nc;
        if (cfg_we) begin
            int sel;
            sel = int'(cfg_addr[5:0]);
            case (cfg_addr[7:6])
                2'b00: if (sel < SLOT_SRC) m_route[sel] = int'(cfg_wdata[2:0]);
                2'b01: if (sel < LINKS) begin m_lirq[sel] = int'(cfg_wdata[5:0]); m_llvl[sel] = cfg_wdata[7]; end
                2'b10: if (sel < EXTRAS) begin
                           m_xirq[sel] = int'(cfg_wdata[5:0]); m_xlvl[sel] = cfg_wdata[6]; m_xen[sel] = cfg_wdata[7];
                       end
                default: ;
            endcase
        end
    endtask

    task automatic compare(input string tag);
        vectors++;
        if (irq_level !== m_act || irq_pulse !== m_pulse || irq_clear !== m_clr) begin
            errors++;
            $display("FAIL %s: level/pulse/clear got %h/%h/%h expected %h/%h/%h",
                     tag, irq_level, irq_pulse, irq_clear, m_act, m_pulse, m_clr);
        end
    endtask

    task automatic expect_lit(input string tag, input logic [15:0] got, input logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle_in();
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        pin_set = '0; pin_clr = '0; ext_set = '0; ext_clr = '0;
        dir_set = 1'b0; dir_clr = 1'b0;
    endtask

    task automatic cycle(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        idle_in();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        cycle("R2");
    endtask

    task automatic program_all();
        wr(8'h40, 8'h85); wr(8'h41, 8'h85); wr(8'h42, 8'h09); wr(8'h43, 8'h94);
        wr(8'h00, 8'd1);  wr(8'h04, 8'd2);  wr(8'h08, 8'd3);  wr(8'h0C, 8'd4);
        wr(8'h05, 8'd5);  wr(8'h09, 8'd2);
        wr(8'h80, 8'hC5); wr(8'h81, 8'h43);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        bit [31:0] r;
        idle_in();
        dir_line = '0; dir_level = 1'b1;
        rst = 1'b1;
        model_reset();
        cycle("R1"); cycle("R1");
        expect_lit("R1", irq_level | irq_pulse | irq_clear, 16'h0000);
        rst = 1'b0;
        cycle("R1");
        expect_lit("R1", irq_level, 16'h0000);
        program_all();

        // R2: unconnected pin (slot0 pinB)
        pin_set[1] = 1'b1; cycle("R2");
        expect_lit("R2", irq_level | irq_pulse, 16'h0000);
        // R3: disabled link, then wrapped entry 5 -> link0 line 5
        pin_set[12] = 1'b1; cycle("R3");
        expect_lit("R3", irq_level | irq_pulse, 16'h0000);
        pin_set[5] = 1'b1; cycle("R3");
        expect_lit("R3", irq_level, 16'h0020);
        pin_clr[5] = 1'b1; cycle("R3");
        expect_lit("R3", irq_clear, 16'h0020);
        // R4: level set, repeated
        pin_set[0] = 1'b1; cycle("R4");
        expect_lit("R4", irq_level, 16'h0020);
        pin_set[0] = 1'b1; cycle("R4");
        expect_lit("R4", irq_pulse, 16'h0000);
        // R6: non-owner clear
        pin_clr[4] = 1'b1; cycle("R6");
        expect_lit("R6", irq_level, 16'h0020);
        // R7: shared release
        pin_set[4] = 1'b1; cycle("R7");
        pin_clr[0] = 1'b1; cycle("R7");
        expect_lit("R7", irq_level, 16'h0020);
        pin_clr[4] = 1'b1; cycle("R7");
        expect_lit("R7", irq_clear, 16'h0020);
        // R5: edge pulse on line 9
        pin_set[8] = 1'b1; cycle("R5");
        expect_lit("R5", irq_pulse, 16'h0200);
        cycle("R5");
        // R8: edge clear over a level owner, then owner release
        dir_line = 4'd9; dir_level = 1'b1; dir_set = 1'b1; cycle("R8");
        expect_lit("R8", irq_level, 16'h0200);
        pin_clr[8] = 1'b1; cycle("R8");
        expect_lit("R8", irq_level, 16'h0000);
        dir_clr = 1'b1; cycle("R8");
        expect_lit("R8", irq_clear, 16'h0200);
        // R9: board sources
        ext_set[0] = 1'b1; ext_set[1] = 1'b1; pin_set[0] = 1'b1; cycle("R9");
        expect_lit("R9", irq_level, 16'h0020);
        ext_clr[0] = 1'b1; cycle("R9");
        expect_lit("R9", irq_level, 16'h0020);
        pin_clr[0] = 1'b1; cycle("R9");
        wr(8'h80, 8'h85);
        ext_set[0] = 1'b1; cycle("R9");
        expect_lit("R9", irq_pulse, 16'h0020);
        // R10: direct source level and edge
        dir_line = 4'd12; dir_level = 1'b1; dir_set = 1'b1; cycle("R10");
        expect_lit("R10", irq_level, 16'h1000);
        dir_line = 4'd3; dir_level = 1'b0; dir_set = 1'b1; cycle("R10");
        expect_lit("R10", irq_pulse, 16'h0008);
        dir_line = 4'd12; dir_level = 1'b1; dir_clr = 1'b1; cycle("R10");
        expect_lit("R10", irq_clear, 16'h1000);
        // R11: same-cycle ordering
        pin_set[0] = 1'b1; pin_clr[0] = 1'b1; cycle("R11");
        expect_lit("R11", irq_clear, 16'h0020);
        pin_set[4] = 1'b1; cycle("R11");
        pin_set[0] = 1'b1; pin_clr[4] = 1'b1; cycle("R11");
        expect_lit("R11", irq_level, 16'h0020);
        pin_clr[0] = 1'b1; cycle("R11");
        // R12: reset drops owners
        pin_set[0] = 1'b1; cycle("R12");
        rst = 1'b1; cycle("R12");
        expect_lit("R12", irq_level, 16'h0000);
        rst = 1'b0;
        program_all();
        pin_clr[0] = 1'b1; cycle("R12");
        expect_lit("R12", irq_clear, 16'h0000);

        // pseudo-random sweep against the model
        r = 32'h1234_5678;
        for (int k = 0; k < 4000; k++) begin
            bit [31:0] a, b;
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5); a = r;
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5); b = r;
            pin_set   = a[15:0] & b[15:0] & a[31:16];
            pin_clr   = b[31:16] & a[15:0] & ~b[15:0];
            ext_set   = a[17:16] & b[19:18];
            ext_clr   = a[21:20] & b[23:22];
            dir_set   = a[24] & b[24];
            dir_clr   = a[25] & b[25];
            dir_line  = b[3:0];
            dir_level = b[26];
            if (a[30:27] == 4'h0) begin
                cfg_we    = 1'b1;
                cfg_addr  = {b[29:28], 2'b00, b[11:8]};
                cfg_wdata = b[23:16];
            end
            cycle("R11");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule